// File: doc/BRIEF.md
# Dual-Law Serial Clock Divider

This block derives the serial clock of an SPI master from the system clock. Two division laws are available and share one divider field. The power-of-two law runs a free-running counter and takes the tap at bit N, so each half-period lasts 2^N system cycles. The linear law counts N+1 system cycles per half-period. In both laws the fastest output is half the system clock rate, reached at N = 0.

While the run input is high, the block drives a registered serial clock level. It also drives two single-cycle strobes for a neighbouring shifter. One strobe marks the move away from the idle level and the other marks the return to it. When run is low, the output rests at the idle level chosen by the polarity input. The law and the divider value are latched together. This happens whenever the block is idle, and again at the close of every full serial clock period. A setting written in the middle of a period therefore never shortens or stretches a half-period that is already under way.

All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready interface and no back-pressure.

Top module: `sclk_rate_gen`

## Requirements
- R1: While reset is asserted, `sclk_o` is 0 and both strobes are 0.
- R2: With the latched law linear (`lin_mode_i` = 1), each level of `sclk_o` lasts N+1 system cycles, where N is the 8-bit `div_val_i` (0..255), giving a period of 2*(N+1) cycles.
- R3: With the latched law power-of-two (`lin_mode_i` = 0), each level of `sclk_o` lasts 2^N system cycles, where N is `div_val_i[3:0]` (0..15), giving a period of 2^(N+1) cycles.
- R4: In the power-of-two law, `div_val_i[7:4]` has no effect on the output timing.
- R5: The law and divider value are captured on every clock edge where `run_i` is low, and on the edge that returns `sclk_o` to idle. A change made at any other time first applies to the following period.
- R6: `lead_o` is high only in the first cycle in which `sclk_o` is at the active level. `trail_o` is high only in the first cycle in which `sclk_o` is back at the idle level after an active half. The two strobes are never high together.
- R7: The idle level equals `cpol_i`, which is sampled only while `run_i` is low, and the active level is its inverse. A change of `cpol_i` while running has no effect until the block next goes idle.
- R8: On the first edge at which `run_i` is low, `sclk_o` returns to the idle level and the count restarts. No strobe is raised for this forced return.
- R9: After `run_i` is first sampled high, `sclk_o` stays at the idle level for exactly one half-period before the first leading transition.
- R10: N = 0 in either law toggles `sclk_o` on every system clock edge, which is the upper bound of the serial clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | High to generate the serial clock, low to idle |
| cpol_i | input | 1 | Idle level of the serial clock |
| lin_mode_i | input | 1 | 1 selects the linear law, 0 the power-of-two law |
| div_val_i | input | 8 | Divider value N (low 4 bits only in the power-of-two law) |
| sclk_o | output | 1 | Serial clock level |
| lead_o | output | 1 | One-cycle strobe: the clock has just left the idle level |
| trail_o | output | 1 | One-cycle strobe: the clock has just returned to the idle level |

## Verification
The assertions assume known, X-free levels on every input from the first edge after reset. The idle-level property also relies on reset having been seen for at least one edge before the sampled cycle. The tap-phase property assumes the exponent comes only from the latched settings. The bench meets these conditions by driving every input at the falling edge and holding them defined throughout. It also keeps the settings stable for several cycles before each run starts and releases reset with run low, so the first capture sees defined settings.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;

  typedef enum logic {
    LAW_POW2   = 1'b0,
    LAW_LINEAR = 1'b1
  } div_law_e;

  localparam int unsigned DEF_VAL_W = 8;
  localparam int unsigned DEF_EXP_W = 4;

endpackage

// File: rtl/sclk_cfg_hold.sv
module sclk_cfg_hold
  import sclk_gen_pkg::*;
#(
  parameter int unsigned VAL_W = DEF_VAL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  div_law_e         law_i,
  input  logic [VAL_W-1:0] val_i,
  output div_law_e         law_o,
  output logic [VAL_W-1:0] val_o
);

  div_law_e         law_q;
  logic [VAL_W-1:0] val_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      law_q <= LAW_POW2;
      val_q <= '0;
    end else if (load_i) begin
      law_q <= law_i;
      val_q <= val_i;
    end
  end

  assign law_o = law_q;
  assign val_o = val_q;

endmodule

// File: rtl/sclk_pow2_tap.sv
module sclk_pow2_tap #(
  parameter int unsigned EXP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tog_o,
  output logic             tap_o
);

  localparam int unsigned CNT_W = 2 ** EXP_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] low_mask;

  // bits below the tap; all ones means the tap flips on the next step
  assign low_mask = ~({CNT_W{1'b1}} << exp_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tog_o = step_i && ((cnt_q & low_mask) == low_mask);
  assign tap_o = cnt_q[exp_i];

endmodule

// File: rtl/sclk_lin_count.sv
module sclk_lin_count #(
  parameter int unsigned VAL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [VAL_W-1:0] lim_i,
  output logic             tog_o
);

  logic [VAL_W-1:0] half_q;
  logic             at_lim;

  assign at_lim = (half_q == lim_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      half_q <= '0;
    end else if (clr_i) begin
      half_q <= '0;
    end else if (step_i) begin
      if (at_lim) half_q <= '0;
      else        half_q <= half_q + 1'b1;
    end
  end

  assign tog_o = step_i && at_lim;

endmodule

// File: rtl/sclk_rate_gen.sv
module sclk_rate_gen
  import sclk_gen_pkg::*;
#(
  parameter int unsigned VAL_W = DEF_VAL_W,
  parameter int unsigned EXP_W = DEF_EXP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             cpol_i,
  input  logic             lin_mode_i,
  input  logic [VAL_W-1:0] div_val_i,
  output logic             sclk_o,
  output logic             lead_o,
  output logic             trail_o
);

  div_law_e         cfg_law;
  logic [VAL_W-1:0] cfg_val;
  logic             lin_tog;
  logic             pow_tog;
  logic             pow_tap;
  logic             tog;
  logic             boundary;
  logic             restart;
  logic             act_q;
  logic             pol_q;
  logic             lead_q;
  logic             trail_q;

  // period boundary: the edge that brings the clock back to idle
  assign tog      = (cfg_law == LAW_LINEAR) ? lin_tog : pow_tog;
  assign boundary = run_i && tog && act_q;
  assign restart  = !run_i || boundary;

  sclk_cfg_hold #(.VAL_W(VAL_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (restart),
    .law_i  (div_law_e'(lin_mode_i)),
    .val_i  (div_val_i),
    .law_o  (cfg_law),
    .val_o  (cfg_val)
  );

  sclk_lin_count #(.VAL_W(VAL_W)) u_lin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart),
    .step_i (run_i),
    .lim_i  (cfg_val),
    .tog_o  (lin_tog)
  );

  sclk_pow2_tap #(.EXP_W(EXP_W)) u_pow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart),
    .step_i (run_i),
    .exp_i  (cfg_val[EXP_W-1:0]),
    .tog_o  (pow_tog),
    .tap_o  (pow_tap)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      pol_q   <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else if (!run_i) begin
      act_q   <= 1'b0;
      pol_q   <= cpol_i;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      lead_q  <= tog && !act_q;
      trail_q <= tog && act_q;
      if (tog) act_q <= !act_q;
    end
  end

  assign sclk_o  = act_q ^ pol_q;
  assign lead_o  = lead_q;
  assign trail_o = trail_q;

endmodule

// File: rtl/sclk_rate_gen_chk.sv
module sclk_rate_gen_chk #(
  parameter int unsigned VAL_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             cpol_i,
  input logic             sclk_o,
  input logic             lead_o,
  input logic             trail_o,
  input logic             law_i,
  input logic [VAL_W-1:0] val_i,
  input logic             act_i,
  input logic             tap_i
);

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lead_o && trail_o)); // R6

  AST_LEAD_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_o |-> (sclk_o != $past(sclk_o))); // R6

  AST_TRAIL_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_o |-> (sclk_o != $past(sclk_o))); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(run_i) |-> (!lead_o && !trail_o)); // R8

  AST_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(run_i)) |-> (sclk_o == $past(cpol_i))); // R7

  AST_TAP_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (law_i == 1'b0) |-> (act_i == tap_i)); // R3

  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && !trail_o) |-> $stable({law_i, val_i})); // R5

endmodule

bind sclk_rate_gen sclk_rate_gen_chk #(.VAL_W(VAL_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run_i   (run_i),
  .cpol_i  (cpol_i),
  .sclk_o  (sclk_o),
  .lead_o  (lead_o),
  .trail_o (trail_o),
  .law_i   (cfg_law),
  .val_i   (cfg_val),
  .act_i   (act_q),
  .tap_i   (pow_tap)
);

// File: tb/sclk_rate_gen_tb_top.sv
module sclk_rate_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       cpol = 1'b0;
  logic       lin = 1'b1;
  logic [7:0] val = 8'd0;
  logic       sclk;
  logic       lead;
  logic       trail;

  int n_chk = 0;
  int n_fail = 0;

  // reference state built from the requirements
  bit m_act, m_pol, m_lead, m_trail;
  int m_cnt, m_half;

  always #2 clk = ~clk;

  sclk_rate_gen dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .run_i      (run),
    .cpol_i     (cpol),
    .lin_mode_i (lin),
    .div_val_i  (val),
    .sclk_o     (sclk),
    .lead_o     (lead),
    .trail_o    (trail)
  );

  // R2 linear: N+1 per level; R3/R4 power-of-two: 2^N using only bits 3:0
  function automatic int half_len(logic l, logic [7:0] v);
    return l ? (int'(v) + 1) : (1 << v[3:0]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_pol = 0; m_lead = 0; m_trail = 0; m_cnt = 0; m_half = 1;
    end else if (!run) begin
      m_act = 0; m_pol = cpol; m_lead = 0; m_trail = 0; m_cnt = 0;
      m_half = half_len(lin, val);
    end else begin
      m_lead = 0; m_trail = 0;
      m_cnt = m_cnt + 1;
      if (m_cnt == m_half) begin
        m_cnt = 0;
        if (m_act) begin
          m_act = 0; m_trail = 1; m_half = half_len(lin, val);
        end else begin
          m_act = 1; m_lead = 1;
        end
      end
    end
  end

  task automatic cmp(string tag);
    bit exp_sclk;
    exp_sclk = m_act ^ m_pol;
    n_chk++;
    if (sclk !== exp_sclk || lead !== m_lead || trail !== m_trail) begin
      n_fail++;
      $display("FAIL %s t=%0t actual sclk=%b lead=%b trail=%b expected sclk=%b lead=%b trail=%b",
               tag, $time, sclk, lead, trail, exp_sclk, m_lead, m_trail);
    end
  endtask

  task automatic cycles(int n, string tag);
    repeat (n) begin
      @(negedge clk);
      cmp(tag);
    end
  endtask

  task automatic setup(logic l, logic [7:0] v, logic p);
    run = 1'b0; lin = l; val = v; cpol = p;
    cycles(3, "R7 idle");
  endtask

  task automatic t_reset;
    cycles(3, "R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    cycles(2, "R1 after reset");
  endtask

  task automatic t_linear;
    setup(1'b1, 8'd0, 1'b0);
    run = 1'b1;
    cycles(12, "R10 R2 linear N=0");
    setup(1'b1, 8'd3, 1'b0);
    run = 1'b1;
    cycles(40, "R9 R2 R6 linear N=3");
    setup(1'b1, 8'd255, 1'b0);
    run = 1'b1;
    cycles(1100, "R2 linear N=255");
  endtask

  task automatic t_pow2;
    setup(1'b0, 8'd0, 1'b0);
    run = 1'b1;
    cycles(12, "R10 R3 pow2 N=0");
    setup(1'b0, 8'd1, 1'b0);
    run = 1'b1;
    cycles(40, "R3 pow2 N=1");
    setup(1'b0, 8'd3, 1'b0);
    run = 1'b1;
    cycles(80, "R9 R3 pow2 N=3");
  endtask

  task automatic t_upper_ignored;
    setup(1'b0, 8'hA2, 1'b0);
    run = 1'b1;
    cycles(40, "R4 pow2 upper bits");
  endtask

  task automatic t_pow2_max;
    setup(1'b0, 8'd15, 1'b0);
    run = 1'b1;
    cycles(32800, "R3 pow2 N=15");
  endtask

  task automatic t_reload;
    setup(1'b1, 8'd4, 1'b0);
    run = 1'b1;
    cycles(3, "R5 before change");
    val = 8'd1;
    lin = 1'b0;
    cycles(40, "R5 mid-period change");
    val = 8'd2;
    cycles(5, "R5 second change");
    lin = 1'b1;
    cycles(40, "R5 law back to linear");
  endtask

  task automatic t_polarity;
    setup(1'b1, 8'd2, 1'b1);
    run = 1'b1;
    cycles(10, "R7 inverted polarity");
    cpol = 1'b0;
    cycles(20, "R7 polarity change while running");
    run = 1'b0;
    cycles(4, "R7 new idle level");
  endtask

  task automatic t_stop;
    setup(1'b1, 8'd5, 1'b0);
    run = 1'b1;
    cycles(8, "R8 before stop");
    run = 1'b0;
    cycles(5, "R8 forced return to idle");
    run = 1'b1;
    cycles(30, "R8 restart");
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_linear();
    t_pow2();
    t_upper_ignored();
    t_reload();
    t_polarity();
    t_stop();
    t_pow2_max();
    setup(1'b1, 8'd0, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule